// File: doc/BRIEF.md
# Processor Clock Power-State Sequencer

This block is the state machine that decides which clock state a processor core is in. It starts in the running state and listens to a halt-instruction strobe, an active-low stop-clock request, a set of break-event lines, an SMI line with its completion handshake, a snoop request and completion, an active-low sleep request and a bus-clock-running flag. From these it moves between seven states. It drives a core clock enable, the encoded current state, single-cycle requests for a halt bus cycle and a stop-grant acknowledge bus cycle, and a wake-ready flag. The gating cell, the bus-cycle generator and the SMI handler sit outside the block.

A strap pin is sampled while reset is held. It selects whether a stop-clock request lands in the high-power grant state, which suits multiprocessor systems, or in the low-power quick-start state, which suits single-processor systems. The block never enters the other one. Any request that the supported transition set does not cover leaves the state unchanged. The exit from the deepest state is timed by a counter whose length is the clock frequency in MHz multiplied by the exit latency in microseconds. With the default parameters this is 100 MHz and 30 us, or 3000 cycles.

State codes: 0 running, 1 auto-halt, 2 stop-grant, 3 quick-start, 4 snoop, 5 sleep, 6 deep sleep.

Top module: `clk_pwr_seq`

## Requirements
- R1: While reset is held and after it is released, state_o is 0, core_clk_en_o is 1, halt_cyc_o and stop_ack_o are 0, and wake_rdy_o is 1.
- R2: strap_qs_ni is sampled on every clock edge while rst_ni is low. If it was sampled low, a stop-clock request enters quick-start (3). Otherwise it enters stop-grant (2). The block never enters the state that was not selected.
- R3: In running state (0), halt_i moves the block to auto-halt (1) and sets halt_cyc_o for exactly that one cycle. core_clk_en_o is 1 only in state 0.
- R4: In auto-halt, any set bit of brk_i or smi_i moves the block to running (0) at the next edge. This has priority over every other request in that state.
- R5: stpclk_ni low in running or in auto-halt moves the block to the strap-selected stop state and sets stop_ack_o for one cycle. In running state, stop-clock takes priority over an SMI return and over halt_i.
- R6: When stpclk_ni goes high in stop-grant or quick-start, the block returns to the state from which stop-clock was entered. It does not set halt_cyc_o.
- R7: An SMI taken from auto-halt is completed by smi_done_i while in running state. If ret_halt_i is 1, the block returns to auto-halt without setting halt_cyc_o. If ret_halt_i is 0, it stays in running state.
- R8: snoop_i in auto-halt, stop-grant or quick-start enters snoop (4). In those states, stop-clock release and sleep take priority over snoop. snoop_done_i returns the block to the state it came from.
- R9: Sleep (5) is entered only from stop-grant, when sleep_ni is low. In sleep, bclk_run_i low enters deep sleep (6). Otherwise sleep_ni high returns the block to stop-grant.
- R10: In deep sleep, wake_rdy_o is 0. After FREQ_MHZ*EXIT_US consecutive edges with bclk_run_i high, the block enters sleep and wake_rdy_o returns to 1. A low bclk_run_i restarts the count.
- R11: A request that the transitions above do not cover leaves state_o unchanged and raises no strobe. Examples are halt_i outside running state, a snoop in running state and a sleep request in quick-start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_qs_ni | input | 1 | Stop-target strap, sampled during reset; low selects quick-start |
| halt_i | input | 1 | Halt-instruction strobe |
| stpclk_ni | input | 1 | Stop-clock request, active low |
| brk_i | input | NUM_BRK | Non-SMI break-event lines |
| smi_i | input | 1 | System-management interrupt |
| smi_done_i | input | 1 | SMI handler completion |
| ret_halt_i | input | 1 | SMI return target: 1 auto-halt, 0 running |
| snoop_i | input | 1 | Snoop request |
| snoop_done_i | input | 1 | Snoop completion |
| sleep_ni | input | 1 | Sleep request, active low |
| bclk_run_i | input | 1 | Bus clock running |
| core_clk_en_o | output | 1 | Core clock enable |
| state_o | output | 3 | Current state code |
| halt_cyc_o | output | 1 | One-cycle halt bus-cycle request |
| stop_ack_o | output | 1 | One-cycle stop-grant acknowledge request |
| wake_rdy_o | output | 1 | Low while in deep sleep; high again once the exit latency has elapsed |

## Verification
The bench builds the block with FREQ_MHZ=1 and EXIT_US=4, so the deep-sleep exit window is four cycles. With a window that short, the random phase reaches a complete exit and also a count restarted by a bus-clock drop, alongside the directed cases. The bench resets twice, with the strap high and then low, so that both stop targets and the refused cross-target cases are exercised from the same instance.

// File: rtl/clk_pwr_pkg.sv
package clk_pwr_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_AHALT = 3'd1,
    ST_SGNT  = 3'd2,
    ST_QSTRT = 3'd3,
    ST_SNOOP = 3'd4,
    ST_SLEEP = 3'd5,
    ST_DEEP  = 3'd6
  } pwr_st_e;
endpackage

// File: rtl/clk_pwr_strap.sv
module clk_pwr_strap (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strap_qs_ni,
  output logic qs_mode_o
);
  logic qs_q;

  // captured only while reset is held, frozen afterwards
  always_ff @(posedge clk_i) begin
    if (!rst_ni) qs_q <= !strap_qs_ni;
  end

  assign qs_mode_o = qs_q;
endmodule

// File: rtl/clk_pwr_wake_timer.sv
module clk_pwr_wake_timer #(
  parameter int unsigned WAKE_CYCLES = 3000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CNT_W = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAKE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || done_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_cnt_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/clk_pwr_fsm.sv
module clk_pwr_fsm
  import clk_pwr_pkg::*;
#(
  parameter int unsigned NUM_BRK = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               qs_mode_i,
  input  logic               halt_i,
  input  logic               stpclk_ni,
  input  logic [NUM_BRK-1:0] brk_i,
  input  logic               smi_i,
  input  logic               smi_done_i,
  input  logic               ret_halt_i,
  input  logic               snoop_i,
  input  logic               snoop_done_i,
  input  logic               sleep_ni,
  input  logic               bclk_run_i,
  input  logic               wake_done_i,
  output pwr_st_e            st_o,
  output logic               halt_cyc_o,
  output logic               stop_ack_o,
  output logic               wake_rdy_o
);
  pwr_st_e st_q, st_d, ret_q, ret_d, snp_q, snp_d, stop_tgt;
  logic    smi_q, smi_d, halt_q, halt_d, ack_q, ack_d, wake_q;
  logic    stp_req, past_vld_q;

  assign stp_req  = !stpclk_ni;
  assign stop_tgt = qs_mode_i ? ST_QSTRT : ST_SGNT;

  always_comb begin
    st_d   = st_q;
    ret_d  = ret_q;
    snp_d  = snp_q;
    smi_d  = smi_q;
    halt_d = 1'b0;
    ack_d  = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (stp_req) begin
          st_d  = stop_tgt;
          ret_d = ST_RUN;
          ack_d = 1'b1;
        end else if (smi_q && smi_done_i) begin
          smi_d = 1'b0;
          if (ret_halt_i) st_d = ST_AHALT;
        end else if (halt_i) begin
          st_d   = ST_AHALT;
          halt_d = 1'b1;
        end
      end
      ST_AHALT: begin
        if ((|brk_i) || smi_i) begin
          st_d = ST_RUN;
          if (smi_i) smi_d = 1'b1;
        end else if (stp_req) begin
          st_d  = stop_tgt;
          ret_d = ST_AHALT;
          ack_d = 1'b1;
        end else if (snoop_i) begin
          st_d  = ST_SNOOP;
          snp_d = ST_AHALT;
        end
      end
      ST_SGNT, ST_QSTRT: begin
        if (!stp_req) begin
          st_d = ret_q;
        end else if (st_q == ST_SGNT && !sleep_ni) begin
          st_d = ST_SLEEP;
        end else if (snoop_i) begin
          st_d  = ST_SNOOP;
          snp_d = st_q;
        end
      end
      ST_SNOOP: if (snoop_done_i) st_d = snp_q;
      ST_SLEEP: begin
        if (!bclk_run_i)   st_d = ST_DEEP;
        else if (sleep_ni) st_d = ST_SGNT;
      end
      ST_DEEP:  if (wake_done_i) st_d = ST_SLEEP;
      default:  st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_RUN;
      ret_q      <= ST_RUN;
      snp_q      <= ST_AHALT;
      smi_q      <= 1'b0;
      halt_q     <= 1'b0;
      ack_q      <= 1'b0;
      wake_q     <= 1'b1;
      past_vld_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      ret_q      <= ret_d;
      snp_q      <= snp_d;
      smi_q      <= smi_d;
      halt_q     <= halt_d;
      ack_q      <= ack_d;
      wake_q     <= (st_d != ST_DEEP);
      past_vld_q <= 1'b1;
    end
  end

  assign st_o       = st_q;
  assign halt_cyc_o = halt_q;
  assign stop_ack_o = ack_q;
  assign wake_rdy_o = wake_q;

  p_halt_origin_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_vld_q && halt_q) |-> (st_q == ST_AHALT && $past(st_q) == ST_RUN));
  p_ack_target_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |-> (st_q == ST_SGNT || st_q == ST_QSTRT));
  p_strap_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_QSTRT |-> qs_mode_i) and (st_q == ST_SGNT |-> !qs_mode_i));
  p_resume_no_halt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_vld_q && st_q == ST_AHALT &&
     ($past(st_q) == ST_SGNT || $past(st_q) == ST_QSTRT)) |-> !halt_q);
  p_deep_entry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_vld_q && st_q == ST_DEEP && $past(st_q) != ST_DEEP) |-> $past(st_q) == ST_SLEEP);
  p_sleep_entry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_vld_q && st_q == ST_SLEEP && $past(st_q) != ST_SLEEP) |->
    ($past(st_q) == ST_SGNT || $past(st_q) == ST_DEEP));
  p_strobe_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(halt_q && ack_q));
  p_wake_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DEEP) |-> !wake_q);
endmodule

// File: rtl/clk_pwr_seq.sv
module clk_pwr_seq
  import clk_pwr_pkg::*;
#(
  parameter int unsigned FREQ_MHZ = 100,
  parameter int unsigned EXIT_US  = 30,
  parameter int unsigned NUM_BRK  = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               strap_qs_ni,
  input  logic               halt_i,
  input  logic               stpclk_ni,
  input  logic [NUM_BRK-1:0] brk_i,
  input  logic               smi_i,
  input  logic               smi_done_i,
  input  logic               ret_halt_i,
  input  logic               snoop_i,
  input  logic               snoop_done_i,
  input  logic               sleep_ni,
  input  logic               bclk_run_i,
  output logic               core_clk_en_o,
  output logic [2:0]         state_o,
  output logic               halt_cyc_o,
  output logic               stop_ack_o,
  output logic               wake_rdy_o
);
  localparam int unsigned WAKE_CYCLES = FREQ_MHZ * EXIT_US;

  logic    qs_mode, wake_run, wake_done;
  pwr_st_e st;

  clk_pwr_strap u_strap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strap_qs_ni (strap_qs_ni),
    .qs_mode_o   (qs_mode)
  );

  assign wake_run = (st == ST_DEEP) && bclk_run_i;

  clk_pwr_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (wake_run),
    .done_o (wake_done)
  );

  clk_pwr_fsm #(.NUM_BRK(NUM_BRK)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .qs_mode_i    (qs_mode),
    .halt_i       (halt_i),
    .stpclk_ni    (stpclk_ni),
    .brk_i        (brk_i),
    .smi_i        (smi_i),
    .smi_done_i   (smi_done_i),
    .ret_halt_i   (ret_halt_i),
    .snoop_i      (snoop_i),
    .snoop_done_i (snoop_done_i),
    .sleep_ni     (sleep_ni),
    .bclk_run_i   (bclk_run_i),
    .wake_done_i  (wake_done),
    .st_o         (st),
    .halt_cyc_o   (halt_cyc_o),
    .stop_ack_o   (stop_ack_o),
    .wake_rdy_o   (wake_rdy_o)
  );

  assign state_o       = st;
  assign core_clk_en_o = (st == ST_RUN);
endmodule

// File: tb/clk_pwr_seq_test.sv
module clk_pwr_seq_test;
  localparam int unsigned NB = 5;
  localparam int unsigned NW = 4;
  localparam logic [2:0] S_RUN = 3'd0, S_AH = 3'd1, S_SG = 3'd2, S_QS = 3'd3,
                         S_SN = 3'd4, S_SL = 3'd5, S_DP = 3'd6;

  logic clk_i = 1'b0, rst_ni = 1'b0, strap_qs_ni = 1'b1;
  logic halt_i, stpclk_ni, smi_i, smi_done_i, ret_halt_i, snoop_i, snoop_done_i;
  logic sleep_ni, bclk_run_i;
  logic [NB-1:0] brk_i;
  logic core_clk_en_o, halt_cyc_o, stop_ack_o, wake_rdy_o;
  logic [2:0] state_o;

  int n_run = 0, n_fail = 0;

  logic [2:0] m_st, m_ret, m_snp;
  logic m_smi, m_qs, m_halt, m_ack;
  int unsigned m_cnt;

  always #5 clk_i = ~clk_i;

  clk_pwr_seq #(.FREQ_MHZ(1), .EXIT_US(NW), .NUM_BRK(NB)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .strap_qs_ni(strap_qs_ni), .halt_i(halt_i),
    .stpclk_ni(stpclk_ni), .brk_i(brk_i), .smi_i(smi_i), .smi_done_i(smi_done_i),
    .ret_halt_i(ret_halt_i), .snoop_i(snoop_i), .snoop_done_i(snoop_done_i),
    .sleep_ni(sleep_ni), .bclk_run_i(bclk_run_i), .core_clk_en_o(core_clk_en_o),
    .state_o(state_o), .halt_cyc_o(halt_cyc_o), .stop_ack_o(stop_ack_o),
    .wake_rdy_o(wake_rdy_o)
  );

  function automatic string req_of(input logic [2:0] s);
    case (s)
      S_RUN: return "R4";
      S_AH:  return "R3";
      S_SG, S_QS: return "R5";
      S_SN:  return "R8";
      S_SL, S_DP: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic idle();
    halt_i = 0; stpclk_ni = 1; brk_i = '0; smi_i = 0; smi_done_i = 0;
    ret_halt_i = 0; snoop_i = 0; snoop_done_i = 0; sleep_ni = 1; bclk_run_i = 1;
  endtask

  // bench reference of the transition rules
  task automatic m_edge();
    logic [2:0] n = m_st;
    logic [2:0] tgt = m_qs ? S_QS : S_SG;
    m_halt = 0; m_ack = 0;
    case (m_st)
      S_RUN: if (!stpclk_ni) begin n = tgt; m_ret = S_RUN; m_ack = 1; end
             else if (m_smi && smi_done_i) begin m_smi = 0; if (ret_halt_i) n = S_AH; end
             else if (halt_i) begin n = S_AH; m_halt = 1; end
      S_AH:  if ((|brk_i) || smi_i) begin n = S_RUN; if (smi_i) m_smi = 1; end
             else if (!stpclk_ni) begin n = tgt; m_ret = S_AH; m_ack = 1; end
             else if (snoop_i) begin n = S_SN; m_snp = S_AH; end
      S_SG, S_QS: if (stpclk_ni) n = m_ret;
             else if (m_st == S_SG && !sleep_ni) n = S_SL;
             else if (snoop_i) begin n = S_SN; m_snp = m_st; end
      S_SN:  if (snoop_done_i) n = m_snp;
      S_SL:  if (!bclk_run_i) n = S_DP; else if (sleep_ni) n = S_SG;
      default: ;
    endcase
    if (m_st == S_DP && bclk_run_i) begin
      if (m_cnt == NW - 1) begin n = S_SL; m_cnt = 0; end
      else m_cnt++;
    end else m_cnt = 0;
    m_st = n;
  endtask

  task automatic check(input string tag);
    logic [6:0] act, exp;
    act = {state_o, core_clk_en_o, halt_cyc_o, stop_ack_o, wake_rdy_o};
    exp = {m_st, m_st == S_RUN, m_halt, m_ack, m_st != S_DP};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {state,clk_en,halt,ack,wake} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk_i);
    m_edge();
    #1;
    check(tag);
  endtask

  task automatic do_reset(input logic strap);
    idle();
    rst_ni = 0; strap_qs_ni = strap;
    repeat (3) @(posedge clk_i);
    #1;
    m_st = S_RUN; m_ret = S_RUN; m_snp = S_AH; m_smi = 0; m_cnt = 0;
    m_halt = 0; m_ack = 0; m_qs = !strap;
    check("R1");
    rst_ni = 1;
    step("R1");
  endtask

  task automatic rand_run(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      halt_i       = ($urandom % 4) == 0;
      stpclk_ni    = ($urandom % 3) != 0;
      brk_i        = (($urandom % 12) == 0) ? NB'(1 << ($urandom % NB)) : '0;
      smi_i        = ($urandom % 16) == 0;
      smi_done_i   = ($urandom % 4) == 0;
      ret_halt_i   = $urandom % 2;
      snoop_i      = ($urandom % 6) == 0;
      snoop_done_i = ($urandom % 2) == 0;
      sleep_ni     = ($urandom % 3) != 0;
      bclk_run_i   = ($urandom % 8) != 0;
      step(req_of(m_st));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset(1'b1);                        // stop-grant selected
    idle(); halt_i = 1; step("R3");        // 0 -> 1 with halt strobe
    idle(); step("R3");                    // strobe one cycle only
    halt_i = 1; step("R11");               // halt in auto-halt refused
    idle(); stpclk_ni = 0; step("R5");     // -> stop-grant, ack
    step("R5");                            // ack one cycle
    snoop_i = 1; step("R8");               // -> snoop
    snoop_i = 0; snoop_done_i = 1; step("R8");  // back to stop-grant
    snoop_done_i = 0; sleep_ni = 0; step("R9"); // -> sleep
    bclk_run_i = 0; step("R9");            // -> deep sleep
    step("R10");
    bclk_run_i = 1; step("R10"); step("R10");
    bclk_run_i = 0; step("R10");           // count restart
    bclk_run_i = 1;
    for (int k = 0; k < NW; k++) step("R10"); // exits on last edge
    sleep_ni = 1; step("R9");              // -> stop-grant
    stpclk_ni = 1; step("R6");             // -> auto-halt, no halt strobe
    brk_i = NB'(1 << 2); step("R4");       // -> running
    idle(); snoop_i = 1; sleep_ni = 0; step("R11"); // refused in running
    idle(); halt_i = 1; step("R3");
    idle(); smi_i = 1; step("R4");         // SMI wakes
    idle(); smi_done_i = 1; ret_halt_i = 1; step("R7"); // back to halt, no strobe
    idle(); smi_i = 1; step("R4");
    idle(); smi_done_i = 1; ret_halt_i = 0; step("R7"); // stays running
    idle(); stpclk_ni = 0; halt_i = 1; step("R5");      // stop-clock wins
    idle(); step("R6");                    // back to running
    rand_run(3000);

    do_reset(1'b0);                        // quick-start selected
    idle(); halt_i = 1; step("R3");
    idle(); stpclk_ni = 0; step("R2");     // -> quick-start
    sleep_ni = 0; step("R11");             // sleep refused in quick-start
    idle(); step("R6");                    // -> auto-halt
    rand_run(3000);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule